// File: doc/BRIEF.md
# Dual-Rail Table-Driven Logic Gate

This block evaluates one two-input Boolean operation on operands held in dual-rail form. Each operand arrives in an 8-bit lane, and only the two lowest bits of the lane carry meaning. The rail pair `01` stands for logic one and `10` stands for logic zero. The two rail pairs are joined into a 4-bit table index. The result is read from a table built for the selected operation: AND, OR or XOR.

Only the four indices made of two legal rail pairs map to a codeword. Every other index maps to the null code `00`. A stuck, flipped or cleared rail therefore collapses to null at the output instead of passing on as a wrong but well-formed value. A reserved operation select also gives null.

The output lane, a three-way result class and a flag for dirty upper lane bits are registered, and they update one clock after the inputs are presented.

Top module: `drgate_lut_gate`

## Requirements
- R1: Lane bits [1:0] hold the rails: `01` is logic 1 and `10` is logic 0. The lookup index is {lane_a[1:0], lane_b[1:0]}, with lane_a in the upper half.
- R2: With op_sel = 2'b10 (XOR), indices 0101 and 1010 give lane_y[1:0] = `10`, and indices 0110 and 1001 give `01`.
- R3: With op_sel = 2'b01 (OR), index 1010 gives `10`, and indices 0101, 0110 and 1001 give `01`.
- R4: With op_sel = 2'b00 (AND), index 0101 gives `01`, and indices 0110, 1001 and 1010 give `10`.
- R5: Any index other than 0101, 0110, 1001 or 1010 gives lane_y = 8'h00 for every operation.
- R6: op_sel = 2'b11 is reserved and gives lane_y = 8'h00 whatever the operands are.
- R7: lane_y[7:2] is always zero.
- R8: lane_a[7:2] and lane_b[7:2] do not change lane_y. in_malformed is 1 exactly when any of those twelve bits was 1.
- R9: y_class reports on lane_y as follows:
  - 2'b00 (NULL) when lane_y is all zero.
  - 2'b01 (VALID) when lane_y is 8'h01 or 8'h02.
  - 2'b10 (INVALID) otherwise.
- R10: lane_y and in_malformed change only at a rising clock edge and reflect the inputs sampled at that edge. While rst_n is low they read lane_y = 0, y_class = NULL and in_malformed = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 10 XOR, 11 reserved |
| lane_a | input | 8 | First operand lane, rails in bits [1:0] |
| lane_b | input | 8 | Second operand lane, rails in bits [1:0] |
| lane_y | output | 8 | Result lane, rails in bits [1:0] |
| y_class | output | 2 | Result class: 00 NULL, 01 VALID, 10 INVALID |
| in_malformed | output | 1 | Some upper operand lane bit was set |

## Verification
The lookup and the upper-bit screen run in the same cycle on the same lanes. A set upper bit must raise in_malformed and must leave the looked-up result untouched.

The bench provokes this by sending every legal and illegal rail index with garbage in the upper six bits of one or both lanes, under each operation. It requires the flag and the untouched result together in the following cycle. A reserved select combined with dirty lanes is judged the same way: a null result with the flag raised.

// File: rtl/drgate_pkg.sv
package drgate_pkg;

  localparam int RAIL_W = 2;
  localparam int IDX_W  = 2 * RAIL_W;
  localparam int TBL_N  = 1 << IDX_W;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_RSVD = 2'b11
  } drg_op_e;

  typedef enum logic [1:0] {
    CLS_NULL    = 2'b00,
    CLS_VALID   = 2'b01,
    CLS_INVALID = 2'b10
  } drg_cls_e;

  localparam logic [RAIL_W-1:0] RAIL_ONE  = 2'b01;
  localparam logic [RAIL_W-1:0] RAIL_ZERO = 2'b10;
  localparam logic [RAIL_W-1:0] RAIL_NULL = 2'b00;

  // A rail pair is a codeword only when exactly one rail is high.
  function automatic logic drg_rails_ok(input logic [RAIL_W-1:0] r);
    return (r == RAIL_ONE) || (r == RAIL_ZERO);
  endfunction

  function automatic logic drg_decode(input logic [RAIL_W-1:0] r);
    return (r == RAIL_ONE);
  endfunction

  function automatic logic [RAIL_W-1:0] drg_encode(input logic v);
    return v ? RAIL_ONE : RAIL_ZERO;
  endfunction

  // Table entry for one operation at one index; illegal pairs give null.
  function automatic logic [RAIL_W-1:0] drg_entry(input drg_op_e op,
                                                  input logic [IDX_W-1:0] idx);
    logic [RAIL_W-1:0] ra;
    logic [RAIL_W-1:0] rb;
    logic              va;
    logic              vb;
    ra = idx[IDX_W-1:RAIL_W];
    rb = idx[RAIL_W-1:0];
    if (!drg_rails_ok(ra) || !drg_rails_ok(rb)) return RAIL_NULL;
    va = drg_decode(ra);
    vb = drg_decode(rb);
    case (op)
      OP_AND:  return drg_encode(va & vb);
      OP_OR:   return drg_encode(va | vb);
      OP_XOR:  return drg_encode(va ^ vb);
      default: return RAIL_NULL;
    endcase
  endfunction

endpackage

// File: rtl/drgate_index.sv
module drgate_index
  import drgate_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  output logic [IDX_W-1:0]  idx,
  output logic              upper_dirty
);

  localparam int UPPER_W = LANE_W - RAIL_W;

  logic [UPPER_W-1:0] up_a;
  logic [UPPER_W-1:0] up_b;

  assign up_a        = lane_a[LANE_W-1:RAIL_W];
  assign up_b        = lane_b[LANE_W-1:RAIL_W];
  assign idx         = {lane_a[RAIL_W-1:0], lane_b[RAIL_W-1:0]};
  assign upper_dirty = (|up_a) | (|up_b);

endmodule

// File: rtl/drgate_table.sv
module drgate_table
  import drgate_pkg::*;
(
  input  logic [1:0]        op_sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [RAIL_W-1:0] rails,
  output logic              hit
);

  logic [RAIL_W-1:0] tbl [TBL_N];
  drg_op_e           op;

  assign op = drg_op_e'(op_sel);

  // One table slot per index, each filled from the entry function.
  for (genvar i = 0; i < TBL_N; i++) begin : g_slot
    assign tbl[i] = drg_entry(op, IDX_W'(i));
  end

  assign rails = tbl[idx];
  assign hit   = (rails != RAIL_NULL);

endmodule

// File: rtl/drgate_classify.sv
module drgate_classify
  import drgate_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane,
  output logic [1:0]        cls
);

  localparam int UPPER_W = LANE_W - RAIL_W;

  logic upper_zero;
  logic rails_ok;

  assign upper_zero = (lane[LANE_W-1:RAIL_W] == UPPER_W'(0));
  assign rails_ok   = drg_rails_ok(lane[RAIL_W-1:0]);

  always_comb begin
    if (lane == LANE_W'(0))        cls = CLS_NULL;
    else if (upper_zero && rails_ok) cls = CLS_VALID;
    else                           cls = CLS_INVALID;
  end

endmodule

// File: rtl/drgate_lut_gate.sv
module drgate_lut_gate
  import drgate_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  output logic [LANE_W-1:0] lane_y,
  output logic [1:0]        y_class,
  output logic              in_malformed
);

  localparam int UPPER_W = LANE_W - RAIL_W;

  logic [IDX_W-1:0]  lut_idx;
  logic              upper_dirty;
  logic [RAIL_W-1:0] lut_rails;
  logic              lut_hit;
  logic [LANE_W-1:0] y_next;

  drgate_index #(.LANE_W(LANE_W)) u_index (
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .idx        (lut_idx),
    .upper_dirty(upper_dirty)
  );

  drgate_table u_table (
    .op_sel(op_sel),
    .idx   (lut_idx),
    .rails (lut_rails),
    .hit   (lut_hit)
  );

  assign y_next = {UPPER_W'(0), lut_rails};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_y       <= '0;
        in_malformed <= 1'b0;
      end else begin
        lane_y       <= y_next;
        in_malformed <= upper_dirty;
      end
    end
  end else begin : g_comb
    assign lane_y       = rst_n ? y_next : '0;
    assign in_malformed = rst_n & upper_dirty;
  end

  drgate_classify #(.LANE_W(LANE_W)) u_classify (
    .lane(lane_y),
    .cls (y_class)
  );

endmodule

// File: rtl/drgate_lut_gate_chk.sv
module drgate_lut_gate_chk
#(
  parameter int LANE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_sel,
  input logic [LANE_W-1:0] lane_a,
  input logic [LANE_W-1:0] lane_b,
  input logic [LANE_W-1:0] lane_y,
  input logic [1:0]        y_class,
  input logic              in_malformed,
  input logic              lut_hit
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: upper output bits stay zero
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lane_y[LANE_W-1:2] == '0);

  // R9: a VALID class implies a one-hot rail pair and a clean upper part
  p_class_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (y_class == 2'b01) |-> ($onehot(lane_y[1:0]) && lane_y[LANE_W-1:2] == '0));

  // R9: an all-zero lane is reported as NULL
  p_class_null_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_y == '0) |-> (y_class == 2'b00));

  if (REG_OUT) begin : g_seq
    // R6: a reserved select gives null
    p_rsvd_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_sel) == 2'b11) |-> (lane_y == '0));

    // R5: a non-codeword operand gives null
    p_illegal_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !($past(lane_a[1:0]) == 2'b01 || $past(lane_a[1:0]) == 2'b10))
        |-> (lane_y == '0));

    // R2: XOR result matches the decoded operands
    p_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_sel) == 2'b10 && $past(lut_hit))
        |-> (lane_y[1:0] == ((($past(lane_a[1:0]) == 2'b01) ^
                              ($past(lane_b[1:0]) == 2'b01)) ? 2'b01 : 2'b10)));

    // R8: the flag follows the upper operand bits one cycle later
    p_malformed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (in_malformed == ($past(|lane_a[LANE_W-1:2]) || $past(|lane_b[LANE_W-1:2]))));

    // R10: the output holds between edges while the inputs are stable
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $stable(lane_a) && $stable(lane_b) && $stable(op_sel)) |=> $stable(lane_y));
  end

endmodule

bind drgate_lut_gate drgate_lut_gate_chk #(.LANE_W(LANE_W), .REG_OUT(REG_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_sel      (op_sel),
  .lane_a      (lane_a),
  .lane_b      (lane_b),
  .lane_y      (lane_y),
  .y_class     (y_class),
  .in_malformed(in_malformed),
  .lut_hit     (lut_hit)
);

// File: tb/drgate_lut_gate_tb.sv
`timescale 1ns/1ps
module drgate_lut_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] lane_a = 8'h00;
  logic [7:0] lane_b = 8'h00;
  logic [7:0] lane_y;
  logic [1:0] y_class;
  logic       in_malformed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  drgate_lut_gate u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .lane_a(lane_a), .lane_b(lane_b),
    .lane_y(lane_y), .y_class(y_class), .in_malformed(in_malformed)
  );

  // Bench model built from the truth statements of R2-R6.
  function automatic logic [7:0] model(input logic [1:0] op, input logic [1:0] a,
                                       input logic [1:0] b);
    logic x;
    logic y;
    if (op == 2'b11) return 8'h00;
    if (!(a == 2'b01 || a == 2'b10) || !(b == 2'b01 || b == 2'b10)) return 8'h00;
    x = a[0];
    y = b[0];
    case (op)
      2'b00:   return (x && y) ? 8'h01 : 8'h02;
      2'b01:   return (x || y) ? 8'h01 : 8'h02;
      default: return (x != y) ? 8'h01 : 8'h02;
    endcase
  endfunction

  function automatic logic [1:0] class_of(input logic [7:0] v);
    if (v == 8'h00) return 2'b00;
    if (v == 8'h01 || v == 8'h02) return 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_sel = op;
    lane_a = a;
    lane_b = b;
    @(negedge clk);
  endtask

  function automatic string req_for(input logic [1:0] op, input logic [7:0] exp);
    if (op == 2'b11) return "R6";
    if (exp == 8'h00) return "R5";
    if (op == 2'b00) return "R4";
    if (op == 2'b01) return "R3";
    return "R2";
  endfunction

  task automatic t_reset();
    chk("R10 reset lane_y", lane_y, 8'h00);
    chk("R10 reset class", {6'b0, y_class}, 8'h00);
    chk("R10 reset malformed", {7'b0, in_malformed}, 8'h00);
  endtask

  task automatic t_sweep_clean();
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] e;
        e = model(op[1:0], i[3:2], i[1:0]);
        apply(op[1:0], {6'b0, i[3:2]}, {6'b0, i[1:0]});
        chk({req_for(op[1:0], e), " R1 lookup"}, lane_y, e);
        chk("R9 class", {6'b0, y_class}, {6'b0, class_of(e)});
        chk("R8 clean flag", {7'b0, in_malformed}, 8'h00);
      end
    end
  endtask

  task automatic t_dirty_upper();
    logic [7:0] pat [4] = '{8'hFC, 8'h04, 8'h80, 8'hA8};
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] e;
        logic [7:0] ga;
        logic [7:0] gb;
        e  = model(op[1:0], i[3:2], i[1:0]);
        ga = ((i % 3) != 0) ? pat[i % 4] : 8'h00;
        gb = ((i % 3) != 1) ? pat[(i + 1) % 4] : 8'h00;
        apply(op[1:0], ga | {6'b0, i[3:2]}, gb | {6'b0, i[1:0]});
        chk("R8 upper bits ignored", lane_y, e);
        chk("R7 upper output zero", {2'b0, lane_y[7:2]}, 8'h00);
        chk("R8 flag", {7'b0, in_malformed}, {7'b0, ((ga | gb) != 8'h00)});
      end
    end
  endtask

  task automatic t_latency();
    apply(2'b10, 8'h01, 8'h01);
    chk("R10 settled", lane_y, 8'h02);
    @(negedge clk);
    op_sel = 2'b10;
    lane_a = 8'h41;
    lane_b = 8'h02;
    #1;
    chk("R10 holds before edge", lane_y, 8'h02);
    chk("R10 flag holds before edge", {7'b0, in_malformed}, 8'h00);
    @(negedge clk);
    chk("R10 updates after edge", lane_y, 8'h01);
    chk("R10 flag after edge", {7'b0, in_malformed}, 8'h01);
  endtask

  task automatic t_reset_mid();
    apply(2'b01, 8'h02, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset lane", lane_y, 8'h00);
    chk("R9 class after reset", {6'b0, y_class}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep_clean();
    t_dirty_upper();
    t_latency();
    t_reset_mid();
    t_sweep_clean();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule